// File: doc/BRIEF.md
# Two-Mode Systolic Off-Diagonal Processing Cell

This block is the interior (off-diagonal) element of a two-phase systolic matrix array. Each cycle it may accept a pair of modification factors from the cell to its left and one data entry from the array row above. It combines them with the value it holds internally, R. The modified entry goes down to the next row, and the factors go on to the right neighbour one cycle later, together with their valid flag.

A mode input chooses what the cell does with a valid entry. In rotation mode it applies a plane rotation to the pair (R, entry): the rotated entry goes down and the rotated R is stored. In elimination mode it subtracts a scaled copy of R from the passing entry and leaves R untouched. All arithmetic is signed Q8.8 fixed point. Products are formed at full width, and each result is rounded once and saturated back to 16 bits. A synchronous clear zeroes R. The array skews its input so that each factor pair and its matching entry arrive in the same cycle. The cell therefore consumes all three together.

Top module: `rotcell_internal`

## Requirements
- R1: While reset is asserted and after its release before any clock edge with valid input, `xout`, `cout`, `sout` and `valid_out` are zero and the stored R is zero.
- R2: In rotation mode (`phase` = 0) with `valid_in` high, `xout` one clock later equals cin·xin − sin·R, computed from the R held before that edge.
- R3: In rotation mode with `valid_in` high and `clear` low, R becomes cin·R + sin·xin, computed from the old R.
- R4: In elimination mode (`phase` = 1) with `valid_in` high, `xout` one clock later equals xin − sin·R, and R keeps its value.
- R5: While `valid_in` is low, R is not written and `xout` holds its previous value, whatever the other inputs are.
- R6: `clear` high at a clock edge sets R to zero. It takes priority over a rotation write in the same cycle.
- R7: `cout`, `sout` and `valid_out` equal the `cin`, `sin` and `valid_in` presented at the previous clock edge.
- R8: A result above 32767 or below −32768 (raw Q8.8 codes) is clamped to 32767 or −32768 respectively.
- R9: All operands and results are two's-complement Q8.8 (raw code 256 = 1.0). The exact sum of products is rounded once, half up toward +∞: add 128, then shift right arithmetically by 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous zeroing of stored R |
| valid_in | input | 1 | Factors and entry on this cycle are valid |
| phase | input | 1 | 0 = rotation mode, 1 = elimination mode |
| cin | input | 16 | Cosine-like factor from the left neighbour, Q8.8 |
| sin | input | 16 | Sine-like or multiplier factor from the left neighbour, Q8.8 |
| xin | input | 16 | Data entry from the row above, Q8.8 |
| xout | output | 16 | Modified entry to the row below, Q8.8 |
| valid_out | output | 1 | Delayed valid flag to the right neighbour |
| cout | output | 16 | Delayed `cin` to the right neighbour |
| sout | output | 16 | Delayed `sin` to the right neighbour |

## Verification
On every cycle, the bound checker confirms that R never moves in elimination mode or while input is invalid. It also confirms that clear leaves R at zero, that the factors and valid flag are forwarded with exactly one cycle of delay, and that `xout` holds when no entry arrives. Only the directed scenarios can show the arithmetic itself. These cover the rotation and elimination results against an independent model, the saturation limits in both directions, half-up rounding at the tie point, and clear taking priority over a simultaneous rotation write. The bench reads R back through the data path by sending an elimination with a unit factor and zero entry, which yields −R.

// File: rtl/rotcell_pkg.sv
package rotcell_pkg;

    // Operating mode selected by the phase pin
    typedef enum logic {
        PH_ROTATE = 1'b0,
        PH_ELIM   = 1'b1
    } phase_e;

    // Index of each product in the multiplier bank
    localparam int MUL_C_R = 0;   // cin * R
    localparam int MUL_S_X = 1;   // sin * xin
    localparam int MUL_C_X = 2;   // cin * xin
    localparam int MUL_S_R = 3;   // sin * R
    localparam int NUM_MUL = 4;

endpackage

// File: rtl/rotcell_mul.sv
module rotcell_mul #(
    parameter int W = 16
) (
    input  logic signed [W-1:0]   a,
    input  logic signed [W-1:0]   b,
    output logic signed [2*W-1:0] p
);
    // Full-width signed product, no truncation
    assign p = a * b;
endmodule

// File: rtl/rotcell_rndsat.sv
module rotcell_rndsat #(
    parameter int W    = 16,
    parameter int FRAC = 8,
    parameter int AW   = 2*W + 2
) (
    input  logic signed [AW-1:0] acc,
    output logic signed [W-1:0]  q
);
    localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);
    localparam logic signed [AW-1:0] MAXV = {{(AW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [AW-1:0] MINV = ~MAXV;

    logic signed [AW-1:0] rounded;

    always_comb begin
        rounded = (acc + HALF) >>> FRAC;
        if (rounded > MAXV) begin
            q = MAXV[W-1:0];
        end else if (rounded < MINV) begin
            q = MINV[W-1:0];
        end else begin
            q = rounded[W-1:0];
        end
    end
endmodule

// File: rtl/rotcell_internal.sv
module rotcell_internal
    import rotcell_pkg::*;
#(
    parameter int W    = 16,
    parameter int FRAC = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                valid_in,
    input  logic                phase,
    input  logic signed [W-1:0] cin,
    input  logic signed [W-1:0] sin,
    input  logic signed [W-1:0] xin,
    output logic signed [W-1:0] xout,
    output logic                valid_out,
    output logic signed [W-1:0] cout,
    output logic signed [W-1:0] sout
);
    localparam int PW = 2 * W;
    localparam int AW = PW + 2;

    typedef struct packed {
        logic signed [W-1:0] r;
        logic signed [W-1:0] x;
        logic signed [W-1:0] c;
        logic signed [W-1:0] s;
        logic                v;
    } cell_st_t;

    cell_st_t st_d, st_q;

    logic signed [W-1:0]  op_a [NUM_MUL];
    logic signed [W-1:0]  op_b [NUM_MUL];
    logic signed [PW-1:0] prod [NUM_MUL];

    logic signed [AW-1:0] acc_r, acc_x, xin_scaled;
    logic signed [W-1:0]  r_new, x_new;
    phase_e               mode;

    assign mode = phase_e'(phase);

    // Operand routing into the multiplier bank
    always_comb begin
        op_a[MUL_C_R] = cin;  op_b[MUL_C_R] = st_q.r;
        op_a[MUL_S_X] = sin;  op_b[MUL_S_X] = xin;
        op_a[MUL_C_X] = cin;  op_b[MUL_C_X] = xin;
        op_a[MUL_S_R] = sin;  op_b[MUL_S_R] = st_q.r;
    end

    for (genvar g = 0; g < NUM_MUL; g++) begin : g_mul
        rotcell_mul #(.W(W)) u_mul (
            .a (op_a[g]),
            .b (op_b[g]),
            .p (prod[g])
        );
    end

    // Exact accumulation before a single rounding step
    always_comb begin
        xin_scaled = AW'(xin) <<< FRAC;
        acc_r = AW'(prod[MUL_C_R]) + AW'(prod[MUL_S_X]);
        if (mode == PH_ROTATE) begin
            acc_x = AW'(prod[MUL_C_X]) - AW'(prod[MUL_S_R]);
        end else begin
            acc_x = xin_scaled - AW'(prod[MUL_S_R]);
        end
    end

    rotcell_rndsat #(.W(W), .FRAC(FRAC), .AW(AW)) u_rs_r (
        .acc (acc_r),
        .q   (r_new)
    );

    rotcell_rndsat #(.W(W), .FRAC(FRAC), .AW(AW)) u_rs_x (
        .acc (acc_x),
        .q   (x_new)
    );

    // Next-state logic
    always_comb begin
        st_d   = st_q;
        st_d.c = cin;
        st_d.s = sin;
        st_d.v = valid_in;
        if (valid_in) begin
            st_d.x = x_new;
            if (mode == PH_ROTATE) begin
                st_d.r = r_new;
            end
        end
        if (clear) begin
            st_d.r = '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign xout      = st_q.x;
    assign valid_out = st_q.v;
    assign cout      = st_q.c;
    assign sout      = st_q.s;

endmodule

// File: rtl/rotcell_internal_chk.sv
module rotcell_internal_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clear,
    input logic                valid_in,
    input logic                phase,
    input logic signed [W-1:0] cin,
    input logic signed [W-1:0] sin,
    input logic signed [W-1:0] xout,
    input logic                valid_out,
    input logic signed [W-1:0] cout,
    input logic signed [W-1:0] sout,
    input logic signed [W-1:0] r_q
);
    AST_ELIM_KEEPS_R: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && !clear) |=> $stable(r_q));                                  // R4

    AST_IDLE_KEEPS_R: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_in && !clear) |=> $stable(r_q));                              // R5

    AST_IDLE_KEEPS_XOUT: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(xout));                                         // R5

    AST_CLEAR_ZEROES_R: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (r_q == '0));                                               // R6

    AST_FACTOR_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cout == $past(cin) && sout == $past(sin)
                   && valid_out == $past(valid_in)));                         // R7
endmodule

bind rotcell_internal rotcell_internal_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .valid_in  (valid_in),
    .phase     (phase),
    .cin       (cin),
    .sin       (sin),
    .xout      (xout),
    .valid_out (valid_out),
    .cout      (cout),
    .sout      (sout),
    .r_q       (st_q.r)
);

// File: tb/rotcell_internal_test.sv
module rotcell_internal_test;
    localparam int CLK_PERIOD = 10;
    localparam int FRAC       = 8;
    localparam int ONE        = 256;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               clear = 1'b0;
    logic               valid_in = 1'b0;
    logic               phase = 1'b0;
    logic signed [15:0] cin = '0;
    logic signed [15:0] sin = '0;
    logic signed [15:0] xin = '0;
    logic signed [15:0] xout, cout, sout;
    logic               valid_out;

    int n_chk  = 0;
    int n_fail = 0;
    longint r_m = 0;   // model of stored R
    longint x_m = 0;   // model of xout

    rotcell_internal uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .valid_in(valid_in),
        .phase(phase), .cin(cin), .sin(sin), .xin(xin),
        .xout(xout), .valid_out(valid_out), .cout(cout), .sout(sout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint fxq(longint acc);
        longint t;
        t = (acc + (64'sd1 <<< (FRAC-1))) >>> FRAC;
        if (t > 32767)  t = 32767;
        if (t < -32768) t = -32768;
        return t;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock of stimulus; starts and ends at a falling edge
    task automatic op(string req, bit v, bit ph, int c, int s, int x, bit clr);
        longint rn, xo;
        valid_in = v; phase = ph; cin = 16'(c); sin = 16'(s); xin = 16'(x); clear = clr;
        if (ph == 1'b0) begin
            rn = fxq(longint'(c) * r_m + longint'(s) * x);
            xo = fxq(longint'(c) * x - longint'(s) * r_m);
        end else begin
            rn = r_m;
            xo = fxq(longint'(x) * ONE - longint'(s) * r_m);
        end
        if (v) begin
            x_m = xo;
            if (ph == 1'b0) r_m = rn;
        end
        if (clr) r_m = 0;
        @(negedge clk);
        chk(req, "xout", longint'(xout), x_m);
        chk("R7", "cout", longint'(cout), longint'(16'(c)) >= 32768 ? longint'(16'(c)) - 65536 : longint'(16'(c)));
        chk("R7", "sout", longint'(sout), longint'(16'(s)) >= 32768 ? longint'(16'(s)) - 65536 : longint'(16'(s)));
        chk("R7", "valid_out", longint'(valid_out), longint'(v));
    endtask

    task automatic load_r(int val);
        op("R2", 1'b1, 1'b0, 0, ONE, val, 1'b0);
    endtask

    task automatic read_r(string req);
        op(req, 1'b1, 1'b1, 0, ONE, 0, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1", "xout", longint'(xout), 0);
        chk("R1", "cout", longint'(cout), 0);
        chk("R1", "sout", longint'(sout), 0);
        chk("R1", "valid_out", longint'(valid_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid_out", longint'(valid_out), 0);
        read_r("R1");
    endtask

    task automatic t_rotation();
        load_r(768);
        read_r("R3");
        op("R2", 1'b1, 1'b0, 154, 205, 512, 1'b0);
        read_r("R3");
        op("R3", 1'b1, 1'b0, -181, 181, -1000, 1'b0);
        read_r("R3");
    endtask

    task automatic t_elim();
        load_r(640);
        op("R4", 1'b1, 1'b1, 77, 300, 1500, 1'b0);
        op("R4", 1'b1, 1'b1, -900, -96, -200, 1'b0);
        read_r("R4");
    endtask

    task automatic t_idle();
        load_r(-512);
        op("R5", 1'b0, 1'b0, 0, ONE, 2000, 1'b0);
        op("R5", 1'b0, 1'b1, 100, 50, 30, 1'b0);
        read_r("R5");
    endtask

    task automatic t_clear();
        load_r(1234);
        op("R6", 1'b0, 1'b1, 0, 0, 0, 1'b1);
        read_r("R6");
        load_r(999);
        op("R6", 1'b1, 1'b0, ONE, ONE, 700, 1'b1);
        read_r("R6");
    endtask

    task automatic t_saturate();
        load_r(32512);
        op("R8", 1'b1, 1'b1, 0, -ONE, 32512, 1'b0);
        chk("R8", "xout high clamp", longint'(xout), 32767);
        op("R8", 1'b1, 1'b1, 0, ONE, -32768, 1'b0);
        chk("R8", "xout low clamp", longint'(xout), -32768);
        op("R8", 1'b1, 1'b0, ONE, ONE, 32000, 1'b0);
        read_r("R8");
    endtask

    task automatic t_round();
        load_r(1);
        op("R9", 1'b1, 1'b1, 0, 128, 0, 1'b0);
        chk("R9", "half tie up to 0", longint'(xout), 0);
        op("R9", 1'b1, 1'b1, 0, -128, 0, 1'b0);
        chk("R9", "half tie up to 1", longint'(xout), 1);
        op("R9", 1'b1, 1'b1, 0, 384, 0, 1'b0);
        chk("R9", "1.5 lsb down to -1", longint'(xout), -1);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_rotation();
        t_elim();
        t_idle();
        t_clear();
        t_saturate();
        t_round();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule